// File: doc/BRIEF.md
# Programmable Delay Glitch Filter

This block is the last stage of a supply fault path. It takes the single-bit result of a fault comparator, which already has hysteresis, and filters it in time. A new input level reaches the output only after it has held without a break for the programmed timeout. A level that comes back earlier is dropped, so short spurious pulses never show up on the output. A transition that does pass is delayed by exactly the timeout.

Time is counted in ticks. A one-cycle `tick_en` strobe sets the timebase. A 1 µs tick with a setting of 100 gives a 100 µs filter. A dwell counter measures how long the input has differed from the filtered output. It clears when the input goes back to the output level. When it reaches the setting, the output flips to the input level. Rising and falling transitions follow the same rule, so a pulse that passes keeps its width. Changing the setting clears the counter, so any measurement in progress starts again.

Top module: `deglitch_filter`

## Requirements
- R1: While reset is asserted and right after it is released, `filt_out` is 0.
- R2: With the clock tick held high and a setting of T, an input pulse lasting W ≤ T cycles never changes `filt_out`.
- R3: With the clock tick held high and a setting of T, the first clock edge that samples a new input level is edge 0. If the new level holds for more than T cycles, `filt_out` takes it on edge T.
- R4: The trailing edge of a pulse that passed is delayed by the same T cycles, so the output pulse is exactly W cycles wide.
- R5: Low-going pulses on a high resting level follow the same rules as R2 to R4.
- R6: A setting of 0 passes the input through with a delay of one register stage: the output changes on edge 0.
- R7: The dwell count advances only on edges where `tick_en` is 1. If ticks fall on edges 0, P, 2P and so on, a level held long enough reaches the output on edge (T-1)·P+1.
- R8: On the first edge that samples a new setting, the count clears and the output holds. The measurement then restarts, and the output changes on edge c+T'+1, where c is that edge and T' is the new setting.
- R9: When the input returns to the output level, the count clears. Two pulses each no longer than T, separated by a one-cycle gap, leave the output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Timebase strobe; each high cycle counts as one tick |
| raw_in | input | 1 | Unfiltered comparator fault bit |
| timeout_in | input | TMO_W | Filter timeout in ticks; 0 means pass-through |
| filt_out | output | 1 | Filtered fault bit |

## Verification
A filtered transition is due on edge T after the first edge that samples a new level, and on edge (T-1)·P+1 when ticks come every P edges. After a setting change c, it is due on edge c+T'+1. The bench drives inputs and samples outputs on falling clock edges. It counts edges from the one that first sees the stimulus, records the index of the first changed sample and the number of changed samples, and compares both with the figures above. Sweeps over T, W and the resting level cover removal, passing, width preservation and pass-through.

// File: rtl/dgf_pkg.sv
package dgf_pkg;

    // Default width of the timeout setting, in ticks.
    localparam int DGF_TMO_W_DEF = 8;

    // Per-cycle decision of the filter.
    typedef enum logic [2:0] {
        ACT_IDLE    = 3'd0,  // input equals output: clear the count
        ACT_WAIT    = 3'd1,  // input differs, no tick this cycle
        ACT_COUNT   = 3'd2,  // input differs, tick present: advance
        ACT_FLIP    = 3'd3,  // count matured: output takes input level
        ACT_RESTART = 3'd4   // setting changed: clear and hold
    } dgf_act_e;

endpackage

// File: rtl/dgf_cfg_track.sv
module dgf_cfg_track #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMO_W-1:0] tmo_in,
    output logic [TMO_W-1:0] tmo_q,
    output logic             restart
);

    logic [TMO_W-1:0] tmo_d;

    always_comb begin
        tmo_d   = tmo_in;
        restart = (tmo_in != tmo_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmo_q <= '0;
        end else begin
            tmo_q <= tmo_d;
        end
    end

endmodule

// File: rtl/dgf_dwell_cnt.sv
module dgf_dwell_cnt #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [TMO_W-1:0] limit,
    output logic [TMO_W-1:0] cnt_q,
    output logic             mature
);

    logic [TMO_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (advance) begin
            cnt_d = cnt_q + 1'b1;
        end
        mature = (cnt_q >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/dgf_decide.sv
module dgf_decide
    import dgf_pkg::*;
(
    input  logic     raw_in,
    input  logic     out_q,
    input  logic     restart,
    input  logic     mature,
    input  logic     tick_en,
    output dgf_act_e act
);

    always_comb begin
        if (restart) begin
            act = ACT_RESTART;
        end else if (raw_in == out_q) begin
            act = ACT_IDLE;
        end else if (mature) begin
            act = ACT_FLIP;
        end else if (tick_en) begin
            act = ACT_COUNT;
        end else begin
            act = ACT_WAIT;
        end
    end

endmodule

// File: rtl/deglitch_filter.sv
module deglitch_filter
    import dgf_pkg::*;
#(
    parameter int TMO_W = DGF_TMO_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             raw_in,
    input  logic [TMO_W-1:0] timeout_in,
    output logic             filt_out
);

    typedef struct packed {
        logic out;
    } dgf_state_t;

    dgf_state_t       st_d, st_q;
    dgf_act_e         act;
    logic [TMO_W-1:0] tmo_lim;
    logic [TMO_W-1:0] dwell_cnt;
    logic             restart;
    logic             mature;
    logic             cnt_clear;
    logic             cnt_adv;

    dgf_cfg_track #(.TMO_W(TMO_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .tmo_in  (timeout_in),
        .tmo_q   (tmo_lim),
        .restart (restart)
    );

    dgf_decide u_dec (
        .raw_in  (raw_in),
        .out_q   (st_q.out),
        .restart (restart),
        .mature  (mature),
        .tick_en (tick_en),
        .act     (act)
    );

    dgf_dwell_cnt #(.TMO_W(TMO_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cnt_clear),
        .advance (cnt_adv),
        .limit   (tmo_lim),
        .cnt_q   (dwell_cnt),
        .mature  (mature)
    );

    always_comb begin
        st_d      = st_q;
        cnt_clear = (act == ACT_IDLE) || (act == ACT_FLIP) || (act == ACT_RESTART);
        cnt_adv   = (act == ACT_COUNT);
        if (act == ACT_FLIP) begin
            st_d.out = raw_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign filt_out = st_q.out;

endmodule

// File: rtl/dgf_checker.sv
module dgf_checker #(
    parameter int TMO_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             raw_in,
    input logic [TMO_W-1:0] timeout_in,
    input logic             filt_out,
    input logic [TMO_W-1:0] cnt_q,
    input logic [TMO_W-1:0] tmo_q
);

    p_reset_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !filt_out);

    p_hold_when_equal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(raw_in) == $past(filt_out)) |-> $stable(filt_out));

    p_flip_follows_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_out) |-> (filt_out == $past(raw_in)));

    p_flip_needs_mature_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_out) |-> ($past(cnt_q) >= $past(tmo_q)));

    p_count_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= tmo_q);

    p_count_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q > $past(cnt_q)) |-> $past(tick_en));

    p_restart_on_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(timeout_in) != $past(tmo_q)) |-> (cnt_q == '0 && $stable(filt_out)));

endmodule

bind deglitch_filter dgf_checker #(.TMO_W(TMO_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .raw_in     (raw_in),
    .timeout_in (timeout_in),
    .filt_out   (filt_out),
    .cnt_q      (dwell_cnt),
    .tmo_q      (tmo_lim)
);

// File: tb/deglitch_filter_test.sv
`timescale 1ns/1ps
module deglitch_filter_test;

    localparam int TMO_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_en = 1'b1;
    logic             raw_in = 1'b0;
    logic [TMO_W-1:0] timeout_in = '0;
    logic             filt_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    deglitch_filter #(.TMO_W(TMO_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .raw_in     (raw_in),
        .timeout_in (timeout_in),
        .filt_out   (filt_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Settle on a resting level with a given setting.
    task automatic settle(input int t, input bit lvl);
        timeout_in = TMO_W'(t);
        raw_in     = lvl;
        tick_en    = 1'b1;
        for (int k = 0; k < t + 6; k++) step();
    endtask

    // One pulse of width w away from resting level b, setting t.
    task automatic run_pulse(input int t, input int w, input bit b);
        int first;
        int cnt;
        int exp_cnt;
        string tag;
        settle(t, b);
        first = -1;
        cnt   = 0;
        raw_in = ~b;
        for (int i = 0; i < w + t + 6; i++) begin
            step();
            if (filt_out != b) begin
                cnt++;
                if (first < 0) first = i;
            end
            if (i == w - 1) raw_in = b;
        end
        exp_cnt = (w > t) ? w : 0;
        tag = b ? "R5" : ((t == 0) ? "R6" : ((w > t) ? "R4" : "R2"));
        check(cnt == exp_cnt, tag, cnt, exp_cnt);
        if (w > t) begin
            tag = b ? "R5" : ((t == 0) ? "R6" : "R3");
            check(first == t, tag, first, t);
        end
    endtask

    initial begin
        int first;
        int cnt;

        // R1: reset state with the input high
        raw_in = 1'b1;
        repeat (3) @(negedge clk);
        check(filt_out == 1'b0, "R1 during reset", filt_out, 0);
        rst_n = 1'b1;
        check(filt_out == 1'b0, "R1 after release", filt_out, 0);
        raw_in = 1'b0;

        // R2..R6: sweep setting, width and resting level
        for (int b = 0; b < 2; b++)
            for (int t = 0; t <= 6; t++)
                for (int w = 1; w <= 9; w++)
                    run_pulse(t, w, b[0]);

        // R7: ticks every 4 edges, setting 3 -> edge (3-1)*4+1 = 9
        settle(3, 1'b0);
        raw_in  = 1'b1;
        tick_en = 1'b1;
        first   = -1;
        for (int i = 0; i < 20; i++) begin
            step();
            if (filt_out && first < 0) first = i;
            tick_en = ((i + 1) % 4 == 0);
        end
        check(first == 9, "R7", first, 9);
        tick_en = 1'b1;

        // R8: setting 8 -> 9 sampled on edge 3 -> edge 3+9+1 = 13
        settle(8, 1'b0);
        raw_in = 1'b1;
        first  = -1;
        for (int i = 0; i < 25; i++) begin
            step();
            if (filt_out && first < 0) first = i;
            if (i == 2) timeout_in = TMO_W'(9);
        end
        check(first == 13, "R8", first, 13);

        // R9: two 4-cycle pulses with a 1-cycle gap, setting 5
        settle(5, 1'b0);
        cnt    = 0;
        raw_in = 1'b1;
        for (int i = 0; i < 20; i++) begin
            step();
            if (filt_out) cnt++;
            raw_in = ((i + 1) < 4) || (((i + 1) >= 5) && ((i + 1) < 9));
        end
        check(cnt == 0, "R9", cnt, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule